// File: doc/BRIEF.md
# Peripheral Bring-Up Reset and Command Permission Gate

This block sits on the host side of a board and controls how a peripheral controller comes out of reset. It keeps the peripheral's active-low reset line driven low until the supply is reported good, the peripheral's park input is high and the reference clock is reported stable, all at once. When that happens it lets the reset line go high. The peripheral then runs its own auto-initialization and raises a busy flag while that runs. Once the flag falls, initialization is complete.

The gate produces two permissions for the host's command engine. Ordinary register commands are allowed at whichever comes first: the peripheral's busy flag completing, or a fixed timeout measured from reset release. Compound commands are allowed only after the busy flag completes. The timeout never allows them, because that wait can last several seconds. A sticky status output marks the case where the timeout opened ordinary commands while compound commands were still held back.

If the supply or the clock report drops, the gate pulls reset low in the same cycle, withdraws everything it has granted and starts over. The timeout is built from a clock-cycles-per-millisecond parameter and a millisecond count, so a small value can be used in simulation.

Top module: `hpg_host_gate`

## Requirements
- R1: After `rst_n` is released, `periph_rst_n` stays 0 until `supply_ok`, `park_hi` and `clk_stable` are sampled 1 together at one clock edge. It goes to 1 right after that edge, called the release edge.
- R2: Once reset has been released, `park_hi` going low has no effect on `periph_rst_n` or on any permission.
- R3: While `supply_ok` or `clk_stable` is 0, all four outputs are 0 in that same cycle, without waiting for an edge. At the next edge all internal progress is cleared, so a later release starts the timeout from zero.
- R4: If initialization has not completed, `std_cmd_ok` goes to 1 right after the edge that is TIMEOUT_MS*CYC_PER_MS edges after the release edge, and not before.
- R5: `periph_busy` passes through two flip-flops. Initialization counts as complete at the third edge that samples `periph_busy` low, provided it was seen high earlier since release. `std_cmd_ok` goes to 1 right after that edge, if the timeout has not already set it.
- R6: `cmp_cmd_ok` goes to 1 only when initialization is complete, as defined in R5. The timeout never sets it.
- R7: `periph_busy` staying low after release without ever having been high is not treated as completion. `cmp_cmd_ok` stays 0.
- R8: `cmp_wait_flag` goes to 1 one edge after the timeout, if initialization was not complete at that edge. It then stays 1, even after completion, until reset is lost or restarted. It never sets when completion comes first or on the same edge as the timeout.
- R9: Once granted, permissions stay 1 even if `periph_busy` rises again, as long as the supply and clock reports stay good.
- R10: While `rst_n` is 0 at a clock edge, all outputs are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| supply_ok | input | 1 | Supply-good report |
| park_hi | input | 1 | Park input, must be high for release |
| clk_stable | input | 1 | Reference clock stable report |
| periph_busy | input | 1 | Peripheral auto-initialization busy flag (asynchronous) |
| periph_rst_n | output | 1 | Active-low reset to the peripheral |
| std_cmd_ok | output | 1 | Ordinary register commands permitted |
| cmp_cmd_ok | output | 1 | Compound commands permitted |
| cmp_wait_flag | output | 1 | Sticky: timeout opened ordinary commands while compound commands still waited |

## Verification
Each release is followed by a busy pulse whose falling edge lands at a chosen point relative to the timeout. The chosen points are well before it, exactly three edges before it (completion and timeout on one edge), two edges before it (completion one edge late), after it, and at random points. These tell apart the two routes to the ordinary permission and fix where the status flag switches over. Runs where busy never rises separate a real completion from a flag that simply sits low. Runs where busy rises again, or where park drops after release, show the grants are held. Dropping the supply report mid-run and releasing again shows the outputs fall in the same cycle and that the timeout restarts from zero.

// File: rtl/hpg_pkg.sv
// Package: shared types and helpers for the host bring-up gate.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package hpg_pkg;

    // Grants derived from internal progress, before live gating.
    typedef struct packed {
        logic std_ok;
        logic cmp_ok;
        logic wait_flag;
    } gate_t;

    // Counter width able to hold values 0..max_val.
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/hpg_sync.sv
// Module: multi-stage synchronizer for a single asynchronous level.
// Assumes: input changes slowly compared to clk; STAGES >= 2.
module hpg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hpg_ms_timer.sv
// Module: millisecond timeout timer, counts while run is high.
// Assumes: run low clears the count on the next edge; expired holds
// once reached until run falls. CYC_PER_MS == 1 drops the prescaler.
module hpg_ms_timer import hpg_pkg::*; #(
    parameter int CYC_PER_MS = 50000,
    parameter int TIMEOUT_MS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int MSW = cnt_width(TIMEOUT_MS);

    logic [MSW-1:0] ms_q;
    logic           tick;

    generate
        if (CYC_PER_MS > 1) begin : g_pre
            localparam int PW = cnt_width(CYC_PER_MS - 1);
            logic [PW-1:0] pre_q;

            // Divide clk down to one tick per millisecond.
            always_ff @(posedge clk) begin
                if (!rst_n || !run)                      pre_q <= '0;
                else if (pre_q == PW'(CYC_PER_MS - 1))   pre_q <= '0;
                else                                     pre_q <= pre_q + 1'b1;
            end

            assign tick = run && (pre_q == PW'(CYC_PER_MS - 1));
        end else begin : g_nopre
            assign tick = run;
        end
    endgenerate

    // Count milliseconds, saturating at the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)                 ms_q <= '0;
        else if (tick && !expired)          ms_q <= ms_q + 1'b1;
    end

    assign expired = (ms_q == MSW'(TIMEOUT_MS));

    // R3
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (ms_q == '0) && !expired);

    // R4
    ms_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ms_q <= MSW'(TIMEOUT_MS));

    // R4
    expired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired && run |=> expired || !run);
endmodule

// File: rtl/hpg_host_gate.sv
// Module: host-side reset release and command permission gate.
// Releases the peripheral reset once supply, park and clock are all good,
// then grants ordinary commands at the earlier of init completion or the
// timeout, and compound commands at init completion only.
// Assumes: rst_n is synchronous; supply_ok, park_hi and clk_stable are
// already in the clk domain; periph_busy is asynchronous.
module hpg_host_gate import hpg_pkg::*; #(
    parameter int CYC_PER_MS  = 50000,
    parameter int TIMEOUT_MS  = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic park_hi,
    input  logic clk_stable,
    input  logic periph_busy,
    output logic periph_rst_n,
    output logic std_cmd_ok,
    output logic cmp_cmd_ok,
    output logic cmp_wait_flag
);
    logic  hold_ok;
    logic  rel_q;
    logic  live;
    logic  busy_s;
    logic  seen_q;
    logic  done_q;
    logic  wait_q;
    logic  tmo;
    gate_t grant;

    assign hold_ok = supply_ok && clk_stable;
    assign live    = hold_ok && rel_q;

    hpg_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (periph_busy),
        .d_sync  (busy_s)
    );

    hpg_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .TIMEOUT_MS(TIMEOUT_MS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (live),
        .expired (tmo)
    );

    // Release reset once all three conditions hold; lose it on any drop.
    always_ff @(posedge clk) begin
        if (!rst_n) rel_q <= 1'b0;
        else        rel_q <= hold_ok && (rel_q || park_hi);
    end

    // Remember that the peripheral reported busy since release.
    always_ff @(posedge clk) begin
        if (!rst_n || !live) seen_q <= 1'b0;
        else if (busy_s)     seen_q <= 1'b1;
    end

    // Mark initialization complete when busy falls after being seen.
    always_ff @(posedge clk) begin
        if (!rst_n || !live)         done_q <= 1'b0;
        else if (seen_q && !busy_s)  done_q <= 1'b1;
    end

    // Record that the timeout opened ordinary commands before completion.
    always_ff @(posedge clk) begin
        if (!rst_n || !live)        wait_q <= 1'b0;
        else if (tmo && !done_q)    wait_q <= 1'b1;
    end

    // Form the grants from progress state.
    always_comb begin
        grant.std_ok    = tmo || done_q;
        grant.cmp_ok    = done_q;
        grant.wait_flag = wait_q;
    end

    // Gate every output with the live supply and clock reports.
    assign periph_rst_n  = live;
    assign std_cmd_ok    = live && grant.std_ok;
    assign cmp_cmd_ok    = live && grant.cmp_ok;
    assign cmp_wait_flag = live && grant.wait_flag;

    // R1
    release_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rel_q) |-> $past(supply_ok && park_hi && clk_stable));

    // R6
    cmp_no_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo && !done_q |-> !cmp_cmd_ok);

    // R9
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_cmd_ok |=> cmp_cmd_ok || !(supply_ok && clk_stable));

    // R8
    wait_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wait_flag |=> cmp_wait_flag || !(supply_ok && clk_stable));

    // R3
    drop_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_ok |=> !seen_q && !done_q);
endmodule

// File: tb/hpg_host_gate_bench.sv
module hpg_host_gate_bench;
    localparam int CPM  = 4;
    localparam int TMS  = 10;
    localparam int TCYC = CPM * TMS;

    logic clk = 1'b0;
    logic rst_n, supply_ok, park_hi, clk_stable, periph_busy;
    logic periph_rst_n, std_cmd_ok, cmp_cmd_ok, cmp_wait_flag;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    hpg_host_gate #(.CYC_PER_MS(CPM), .TIMEOUT_MS(TMS)) u_hpg_host_gate (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .park_hi(park_hi),
        .clk_stable(clk_stable), .periph_busy(periph_busy),
        .periph_rst_n(periph_rst_n), .std_cmd_ok(std_cmd_ok),
        .cmp_cmd_ok(cmp_cmd_ok), .cmp_wait_flag(cmp_wait_flag)
    );

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            n_fail  = n_fail + 1;
            n_tests = n_tests + 1;
            $display("FAIL watchdog: actual hung, expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b (t=%0t)", req, what, got, exp, $time);
        end
    endtask

    // Expected values j edges after the release edge, busy falling at driven index f.
    function automatic bit exp_std(int j, int f, bit nb);
        return (j >= TCYC) || (!nb && j >= f + 3);
    endfunction
    function automatic bit exp_cmp(int j, int f, bit nb);
        return !nb && (j >= f + 3);
    endfunction
    function automatic bit exp_wait(int j, int f, bit nb);
        return (j >= TCYC + 1) && (nb || (f + 3 >= TCYC + 1));
    endfunction

    // Drop supply, check immediate clear, and settle the synchronizer.
    task automatic drop_supply();
        periph_busy = 1'b0;
        supply_ok = 1'b0;
        #1;
        chk(periph_rst_n, 1'b0, "R3", "rst on drop");
        chk(std_cmd_ok,   1'b0, "R3", "std on drop");
        chk(cmp_cmd_ok,   1'b0, "R3", "cmp on drop");
        chk(cmp_wait_flag,1'b0, "R3", "wait on drop");
        repeat (3) @(posedge clk);
        #1;
    endtask

    // One release with busy high over driven indices [2,f), optional re-rise.
    task automatic trial(input int f, input bit nb, input bit rehigh, input bit parkdrop);
        int n;
        supply_ok = 1'b1; park_hi = 1'b1; clk_stable = 1'b1; periph_busy = 1'b0;
        @(posedge clk); #1;
        chk(periph_rst_n, 1'b1, "R1", "release edge");
        periph_busy = 1'b0;
        n = ((f + 3 > TCYC) ? f + 3 : TCYC) + 6;
        for (int j = 1; j <= n; j++) begin
            @(posedge clk); #1;
            if (parkdrop && j == 1) park_hi = 1'b0;
            chk(periph_rst_n,  1'b1, parkdrop ? "R2" : "R1", "rst held");
            chk(std_cmd_ok,    exp_std(j, f, nb),  nb ? "R4" : "R5", "std");
            chk(cmp_cmd_ok,    exp_cmp(j, f, nb),  nb ? "R7" : (rehigh ? "R9" : "R6"), "cmp");
            chk(cmp_wait_flag, exp_wait(j, f, nb), "R8", "wait");
            periph_busy = !nb && ((j >= 2 && j < f) || (rehigh && j >= f + 5));
        end
        drop_supply();
    endtask

    initial begin
        void'($urandom(32'd7741));
        rst_n = 1'b0; supply_ok = 1'b1; park_hi = 1'b1; clk_stable = 1'b1; periph_busy = 1'b1;
        repeat (3) @(posedge clk); #1;
        chk(periph_rst_n, 1'b0, "R10", "reset rst");
        chk(std_cmd_ok,   1'b0, "R10", "reset std");
        chk(cmp_cmd_ok,   1'b0, "R10", "reset cmp");
        chk(cmp_wait_flag,1'b0, "R10", "reset wait");
        supply_ok = 1'b0; park_hi = 1'b0; periph_busy = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(posedge clk); #1;
        // R1: park low holds reset even with supply and clock good
        supply_ok = 1'b1;
        repeat (5) @(posedge clk); #1;
        chk(periph_rst_n, 1'b0, "R1", "park low holds");
        clk_stable = 1'b0; park_hi = 1'b1;
        repeat (2) @(posedge clk); #1;
        chk(periph_rst_n, 1'b0, "R1", "clk unstable holds");
        supply_ok = 1'b0;
        @(posedge clk); #1;

        trial(4, 1'b0, 1'b0, 1'b0);          // early completion
        trial(TCYC - 3, 1'b0, 1'b0, 1'b0);   // completion on the timeout edge
        trial(TCYC - 2, 1'b0, 1'b0, 1'b0);   // completion one edge late
        trial(TCYC + 10, 1'b0, 1'b0, 1'b0);  // long init
        trial(0, 1'b1, 1'b0, 1'b0);          // R7: busy never rises
        trial(8, 1'b0, 1'b1, 1'b1);          // R9 re-rise, R2 park drop

        // R3: drop mid-run then restart timeout from zero
        supply_ok = 1'b1; park_hi = 1'b1; clk_stable = 1'b1;
        @(posedge clk);
        repeat (TCYC - 5) @(posedge clk);
        #1;
        clk_stable = 1'b0;
        #1;
        chk(periph_rst_n, 1'b0, "R3", "clk drop rst");
        @(posedge clk); #1;
        clk_stable = 1'b1;
        @(posedge clk); #1;
        repeat (TCYC - 1) @(posedge clk);
        #1;
        chk(std_cmd_ok, 1'b0, "R3", "timeout restarted");
        @(posedge clk); #1;
        chk(std_cmd_ok, 1'b1, "R4", "timeout after restart");
        drop_supply();

        for (int k = 0; k < 10; k++) begin
            trial(4 + int'($urandom_range(0, TCYC + 20)), 1'b0, 1'b0, 1'b0);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule